// File: doc/BRIEF.md
# Burst memory responder

This block stands in for main memory behind a cache's line-fill and write-back port, so that a cache can be checked in a closed loop without a behavioural memory model. A single request channel with valid/ready handshaking carries a 4-bit command, an address, 64-bit write data and a byte mask. Responses return on a channel that has a valid strobe and a 4-bit command code. The code does two jobs: it marks the final beat of a read and it marks each write acknowledgement. There is no separate end-of-burst wire.

A read-burst request returns a fixed number of consecutive 64-bit words from a small on-chip RAM. Write beats land at consecutive words and are acknowledged one at a time. One cycle with response valid low always separates the accepting edge from the first response. While a response is pending or streaming, the request channel is held not-ready, so only one request is ever in flight. The RAM is indexed by word address bits above the byte offset, and addresses wrap modulo the RAM depth.

Top module: `burst_mem_responder`

## Requirements
- R1: A request with command 4'b0010 (read burst) produces exactly BEATS (default 8) response beats of DW (default 64) bits, with rsp_valid_o high in BEATS consecutive cycles, followed by rsp_valid_o low.
- R2: In a read burst, every beat except the last carries rsp_cmd_o 4'b0000, and the last beat carries 4'b0110.
- R3: Read beat i returns the word at word index (req_addr_i[3 +: log2(DEPTH)] + i) mod DEPTH. Address bits [2:0] and all bits above the index do not affect the result.
- R4: After a read-burst or write-beat request is accepted, the next cycle has rsp_valid_o low, and the first response appears in the cycle after that.
- R5: Each write beat (command 4'b0011 for a continuing beat, 4'b0111 for the final beat) gets exactly one response with rsp_cmd_o 4'b0101 and rsp_rdata_o zero, two cycles after acceptance. req_ready_o is high again in the following cycle.
- R6: The first write beat after reset, after a 4'b0111 beat or after a read burst is stored at the word index of its own address. Every later beat of the same burst ignores its address and is stored at the previous beat's index plus one.
- R7: Bit b of req_wmask_i enables writing byte b (data bits 8b+7 to 8b). Masked-off bytes keep their old value.
- R8: req_ready_o is low from the cycle after a read-burst or write-beat acceptance until the last response of that request has been shown. A request offered while ready is low is not taken and has no effect on memory.
- R9: Both read and write word indices wrap from DEPTH-1 to 0 (DEPTH a power of two).
- R10: Any other command code is accepted, produces no response, keeps req_ready_o high and changes no memory word.
- R11: During and right after reset, req_ready_o is high, rsp_valid_o is low and rsp_rdata_o is zero.
- R12: Whenever rsp_valid_o is low, rsp_cmd_o and rsp_rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_cmd_i | input | 4 | Request command code |
| req_addr_i | input | AW | Byte address of the request |
| req_wdata_i | input | DW | Write data for a write beat |
| req_wmask_i | input | DW/8 | Byte write enables |
| rsp_valid_o | output | 1 | Response beat present |
| rsp_cmd_o | output | 4 | Response command code (data, last data, write ack) |
| rsp_rdata_o | output | DW | Read data, zero outside read beats |

## Verification
The bench aims at the pointer edges. It reads from index DEPTH-3 and writes a burst that crosses the top of the RAM; a design without wrap would return words from the wrong place or write outside the array. It sends write bursts whose later beats carry random addresses, and leaves bursts open before a read. A design that trusted each beat's address, or kept a write burst open across a read, would scatter words and fail on the final sweep of the whole memory. During reads it holds a write request on the port, which catches a design that took requests while busy. It also sends undefined command codes, which catches a design that answered them or wrote memory on them. Sparse byte masks catch lane mix-ups, and the check of the last-beat code catches an off-by-one in the beat count.

// File: rtl/burst_rsp_pkg.sv
package burst_rsp_pkg;

  localparam int CMD_W = 4;
  typedef logic [CMD_W-1:0] cmd_t;

  // request codes
  localparam cmd_t CMD_RD_BURST = 4'b0010;
  localparam cmd_t CMD_WR_BURST = 4'b0011;
  localparam cmd_t CMD_WR_LAST  = 4'b0111;

  // response codes
  localparam cmd_t RSP_RD_DATA  = 4'b0000;
  localparam cmd_t RSP_RD_LAST  = 4'b0110;
  localparam cmd_t RSP_WR_ACK   = 4'b0101;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_READ,
    ST_ACK
  } rsp_state_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_READ,
    KIND_WRITE
  } req_kind_e;

  function automatic req_kind_e decode_kind(input cmd_t cmd);
    if (cmd == CMD_RD_BURST) begin
      return KIND_READ;
    end else if ((cmd == CMD_WR_BURST) || (cmd == CMD_WR_LAST)) begin
      return KIND_WRITE;
    end else begin
      return KIND_NONE;
    end
  endfunction

endpackage

// File: rtl/burst_rsp_ctrl.sv
module burst_rsp_ctrl
  import burst_rsp_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  req_kind_e req_kind_i,
  output logic      req_ready_o,
  output logic      rsp_valid_o,
  output logic      rsp_read_o,
  output logic      rsp_last_o,
  output logic      beat_adv_o
);

  localparam int            BW        = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  rsp_state_e    state_q, state_d;
  logic          pend_rd_q, pend_rd_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          take;

  assign req_ready_o = (state_q == ST_IDLE);
  assign take        = req_ready_o && req_valid_i && (req_kind_i != KIND_NONE);

  // next state
  always_comb begin
    state_d   = state_q;
    pend_rd_d = pend_rd_q;
    cnt_d     = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          state_d   = ST_GAP;
          pend_rd_d = (req_kind_i == KIND_READ);
        end
      end
      ST_GAP: begin
        cnt_d   = '0;
        state_d = pend_rd_q ? ST_READ : ST_ACK;
      end
      ST_READ: begin
        if (cnt_q == LAST_BEAT) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + BW'(1);
        end
      end
      ST_ACK: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_rd_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_d;
      pend_rd_q <= pend_rd_d;
      cnt_q     <= cnt_d;
    end
  end

  assign rsp_valid_o = (state_q == ST_READ) || (state_q == ST_ACK);
  assign rsp_read_o  = (state_q == ST_READ);
  assign rsp_last_o  = (state_q == ST_READ) && (cnt_q == LAST_BEAT);
  assign beat_adv_o  = (state_q == ST_READ);

endmodule

// File: rtl/burst_rsp_ptr.sv
module burst_rsp_ptr #(
  parameter int AW    = 32,
  parameter int IW    = 6,
  parameter int OFF_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_rd_i,
  input  logic          acc_wr_i,
  input  logic          wr_last_i,
  input  logic          beat_adv_i,
  input  logic [AW-1:0] req_addr_i,
  output logic [IW-1:0] rd_idx_o,
  output logic [IW-1:0] wr_idx_o
);

  logic [IW-1:0] addr_idx;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          wr_open_q, wr_open_d;
  logic          ptr_en;
  logic          unused_addr_bits;

  assign addr_idx         = req_addr_i[OFF_W +: IW];
  assign unused_addr_bits = ^{req_addr_i[OFF_W-1:0], req_addr_i[AW-1:OFF_W+IW]};

  // a continuing write beat follows the pointer, a fresh one its address
  assign wr_idx_o = wr_open_q ? ptr_q : addr_idx;
  assign rd_idx_o = ptr_q;
  assign ptr_en   = acc_rd_i || acc_wr_i || beat_adv_i;

  always_comb begin
    ptr_d     = ptr_q;
    wr_open_d = wr_open_q;
    if (acc_rd_i) begin
      ptr_d     = addr_idx;
      wr_open_d = 1'b0;
    end else if (acc_wr_i) begin
      ptr_d     = wr_idx_o + IW'(1);
      wr_open_d = !wr_last_i;
    end else if (beat_adv_i) begin
      ptr_d     = ptr_q + IW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      wr_open_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q     <= ptr_d;
      wr_open_q <= wr_open_d;
    end
  end

endmodule

// File: rtl/burst_rsp_ram.sv
module burst_rsp_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 64,
  parameter int IW    = 6
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [IW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IW-1:0]   raddr_i,
  output logic [DW-1:0]   rdata_o
);

  localparam int LANES = DW / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) begin
        lane_mem[waddr_i] <= wdata_i[g*8 +: 8];
      end
    end

    assign rdata_o[g*8 +: 8] = lane_mem[raddr_i];
  end

endmodule

// File: rtl/burst_mem_responder.sv
module burst_mem_responder
  import burst_rsp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  parameter int BEATS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW/8-1:0]   req_wmask_i,
  output logic              rsp_valid_o,
  output logic [CMD_W-1:0]  rsp_cmd_o,
  output logic [DW-1:0]     rsp_rdata_o
);

  localparam int IW    = $clog2(DEPTH);
  localparam int OFF_W = $clog2(DW / 8);

  req_kind_e     kind;
  logic          accept;
  logic          acc_rd;
  logic          acc_wr;
  logic          rsp_read;
  logic          rsp_last;
  logic          beat_adv;
  logic [IW-1:0] rd_idx;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] ram_rdata;

  assign kind   = decode_kind(req_cmd_i);
  assign accept = req_valid_i && req_ready_o;
  assign acc_rd = accept && (kind == KIND_READ);
  assign acc_wr = accept && (kind == KIND_WRITE);

  burst_rsp_ctrl #(
    .BEATS (BEATS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (kind),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_read_o  (rsp_read),
    .rsp_last_o  (rsp_last),
    .beat_adv_o  (beat_adv)
  );

  burst_rsp_ptr #(
    .AW    (AW),
    .IW    (IW),
    .OFF_W (OFF_W)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_rd_i   (acc_rd),
    .acc_wr_i   (acc_wr),
    .wr_last_i  (req_cmd_i == CMD_WR_LAST),
    .beat_adv_i (beat_adv),
    .req_addr_i (req_addr_i),
    .rd_idx_o   (rd_idx),
    .wr_idx_o   (wr_idx)
  );

  burst_rsp_ram #(
    .DEPTH (DEPTH),
    .DW    (DW),
    .IW    (IW)
  ) u_ram (
    .clk_i   (clk_i),
    .we_i    (acc_wr),
    .be_i    (req_wmask_i),
    .waddr_i (wr_idx),
    .wdata_i (req_wdata_i),
    .raddr_i (rd_idx),
    .rdata_o (ram_rdata)
  );

  // response encoding
  always_comb begin
    rsp_cmd_o   = RSP_RD_DATA;
    rsp_rdata_o = '0;
    if (rsp_valid_o) begin
      if (rsp_read) begin
        rsp_cmd_o   = rsp_last ? RSP_RD_LAST : RSP_RD_DATA;
        rsp_rdata_o = ram_rdata;
      end else begin
        rsp_cmd_o   = RSP_WR_ACK;
      end
    end
  end

endmodule

// File: rtl/burst_mem_responder_chk.sv
module burst_mem_responder_chk
  import burst_rsp_pkg::*;
#(
  parameter int DW    = 64,
  parameter int BEATS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [CMD_W-1:0] req_cmd_i,
  input logic             rsp_valid_o,
  input logic [CMD_W-1:0] rsp_cmd_o,
  input logic [DW-1:0]    rsp_rdata_o
);

  localparam int CW = $clog2(BEATS) + 1;

  logic          took_burst;
  logic          took_other;
  logic          is_data;
  logic          is_last;
  logic          is_ack;
  logic [CW-1:0] beat_cnt_q;

  assign took_burst = req_valid_i && req_ready_o &&
                      ((req_cmd_i == CMD_RD_BURST) || (req_cmd_i == CMD_WR_BURST) ||
                       (req_cmd_i == CMD_WR_LAST));
  assign took_other = req_valid_i && req_ready_o && !took_burst;
  assign is_data    = rsp_valid_o && (rsp_cmd_o == RSP_RD_DATA);
  assign is_last    = rsp_valid_o && (rsp_cmd_o == RSP_RD_LAST);
  assign is_ack     = rsp_valid_o && (rsp_cmd_o == RSP_WR_ACK);

  // counts data beats seen before the closing beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_cnt_q <= '0;
    end else if (is_data) begin
      beat_cnt_q <= beat_cnt_q + CW'(1);
    end else if (is_last) begin
      beat_cnt_q <= '0;
    end
  end

  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_last |-> (beat_cnt_q == CW'(BEATS - 1)));

  p_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_last |=> (!rsp_valid_o && req_ready_o));

  p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_data |-> (beat_cnt_q < CW'(BEATS - 1)));

  p_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (is_data || is_last || is_ack));

  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took_burst |=> (!rsp_valid_o && !req_ready_o));

  p_ack_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ack |=> (!rsp_valid_o && req_ready_o));

  p_ack_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ack |-> (rsp_rdata_o == '0));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  p_other_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took_other |=> (!rsp_valid_o && req_ready_o));

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> ((rsp_rdata_o == '0) && (rsp_cmd_o == '0)));

  always_comb begin
    if (!rst_ni) begin
      p_reset_r11: assert (req_ready_o && !rsp_valid_o);
    end
  end

endmodule

bind burst_mem_responder burst_mem_responder_chk #(
  .DW    (DW),
  .BEATS (BEATS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_cmd_i   (req_cmd_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_cmd_o   (rsp_cmd_o),
  .rsp_rdata_o (rsp_rdata_o)
);

// File: tb/burst_mem_responder_tb.sv
`timescale 1ns/1ps
module burst_mem_responder_tb;

  localparam int AW    = 32;
  localparam int DW    = 64;
  localparam int DEPTH = 64;
  localparam int BEATS = 8;

  localparam logic [3:0] C_RD   = 4'b0010;
  localparam logic [3:0] C_WR   = 4'b0011;
  localparam logic [3:0] C_WRL  = 4'b0111;
  localparam logic [3:0] R_DATA = 4'b0000;
  localparam logic [3:0] R_LAST = 4'b0110;
  localparam logic [3:0] R_ACK  = 4'b0101;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [3:0]    req_cmd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [7:0]    req_wmask;
  logic          rsp_valid;
  logic [3:0]    rsp_cmd;
  logic [DW-1:0] rsp_rdata;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [63:0] mdl [DEPTH];
  int          wptr  = 0;
  bit          wopen = 1'b0;

  burst_mem_responder #(
    .AW    (AW),
    .DW    (DW),
    .DEPTH (DEPTH),
    .BEATS (BEATS)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_cmd_i   (req_cmd),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_wmask_i (req_wmask),
    .rsp_valid_o (rsp_valid),
    .rsp_cmd_o   (rsp_cmd),
    .rsp_rdata_o (rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic int widx(input logic [AW-1:0] a);
    return int'((a >> 3) & AW'(DEPTH - 1));
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw,
                                        input logic [7:0] m);
    logic [63:0] r;
    r = old;
    for (int b = 0; b < 8; b++) begin
      if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // one write beat; entered and left at a falling edge
  task automatic wr_beat(input logic [3:0] cmd, input logic [AW-1:0] addr,
                         input logic [63:0] data, input logic [7:0] mask, input string tag);
    int idx;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_wdata = data; req_wmask = mask;
    idx = wopen ? wptr : widx(addr);
    mdl[idx] = merge(mdl[idx], data, mask);
    wptr  = (idx + 1) % DEPTH;
    wopen = (cmd == C_WR);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 gap before ack", {63'd0, rsp_valid}, 64'd0);
    chk("R12 quiet data", rsp_rdata, 64'd0);
    chk("R8 ready low", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    chk({tag, " R5 ack valid"}, {63'd0, rsp_valid}, 64'd1);
    chk("R5 ack code", {60'd0, rsp_cmd}, {60'd0, R_ACK});
    chk("R5 ack data", rsp_rdata, 64'd0);
    @(negedge clk);
    chk("R5 single ack", {63'd0, rsp_valid}, 64'd0);
    chk("R8 ready back", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic wr_burst(input logic [AW-1:0] addr, input int len, input bit close,
                          input bit full_mask, input string tag);
    for (int k = 0; k < len; k++) begin
      logic [3:0] c;
      c = (close && (k == len - 1)) ? C_WRL : C_WR;
      // later beats carry junk addresses on purpose (R6)
      wr_beat(c, (k == 0) ? addr : $urandom(), rnd64(),
              full_mask ? 8'hFF : 8'($urandom()), tag);
    end
  endtask

  task automatic rd_burst(input logic [AW-1:0] addr, input bit poke, input string tag);
    int base;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = C_RD; req_addr = addr;
    base  = widx(addr);
    wopen = 1'b0;
    @(negedge clk);
    if (poke) begin
      req_cmd = C_WR; req_addr = $urandom(); req_wdata = rnd64(); req_wmask = 8'hFF;
    end else begin
      req_valid = 1'b0;
    end
    chk("R4 gap before data", {63'd0, rsp_valid}, 64'd0);
    chk("R12 quiet in gap", rsp_rdata, 64'd0);
    for (int i = 0; i < BEATS; i++) begin
      @(negedge clk);
      chk("R1 beat valid", {63'd0, rsp_valid}, 64'd1);
      chk("R2 beat code", {60'd0, rsp_cmd}, {60'd0, (i == BEATS - 1) ? R_LAST : R_DATA});
      chk(tag, rsp_rdata, mdl[(base + i) % DEPTH]);
      chk("R8 ready low in burst", {63'd0, req_ready}, 64'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 burst ends", {63'd0, rsp_valid}, 64'd0);
    chk("R8 ready after burst", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic other_cmd(input logic [3:0] cmd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = $urandom();
    req_wdata = rnd64(); req_wmask = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 no response", {63'd0, rsp_valid}, 64'd0);
    chk("R10 ready stays", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    chk("R10 still silent", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R12 idle valid", {63'd0, rsp_valid}, 64'd0);
      chk("R12 idle data", rsp_rdata, 64'd0);
      chk("R12 idle code", {60'd0, rsp_cmd}, 64'd0);
    end
  endtask

  function automatic logic [3:0] pick_other();
    logic [3:0] c;
    c = 4'($urandom());
    while ((c == C_RD) || (c == C_WR) || (c == C_WRL)) c = 4'($urandom());
    return c;
  endfunction

  initial begin
    int unsigned seed_set;
    seed_set  = $urandom(32'd51977);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_cmd   = '0;
    req_addr  = '0;
    req_wdata = '0;
    req_wmask = '0;
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", {63'd0, req_ready}, 64'd1);
    chk("R11 valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R11 data in reset", rsp_rdata, 64'd0);
    rst_n = 1'b1;
    idle(2);

    // fill the RAM with full-mask bursts whose later addresses are junk
    for (int b = 0; b < DEPTH / BEATS; b++) begin
      wr_burst(AW'(b * BEATS * 8), BEATS, 1'b1, 1'b1, "R6 fill");
    end
    for (int b = 0; b < DEPTH / BEATS; b++) begin
      rd_burst(AW'(b * BEATS * 8), 1'b0, "R3 readback");
    end

    // wrap on read, with offset and high address bits set (R9, R3)
    rd_burst(32'hF000_0000 | AW'((DEPTH - 3) * 8) | 32'h5, 1'b0, "R9 R3 read wrap");
    // write burst across the top of the RAM (R9, R6)
    wr_burst(32'h0000_1000 | AW'((DEPTH - 2) * 8), 5, 1'b1, 1'b1, "R9 write wrap");
    rd_burst(AW'((DEPTH - 4) * 8), 1'b0, "R9 R6 wrap readback");

    // byte masks (R7)
    wr_beat(C_WRL, AW'(16 * 8), 64'hFFFF_FFFF_FFFF_FFFF, 8'hA5, "R7");
    wr_beat(C_WRL, AW'(17 * 8), 64'h0123_4567_89AB_CDEF, 8'h00, "R7");
    wr_beat(C_WRL, AW'(18 * 8), 64'h0, 8'h81, "R7");
    rd_burst(AW'(16 * 8), 1'b0, "R7 masked readback");

    // undefined codes, then check the whole RAM is untouched (R10)
    other_cmd(4'b0000);
    other_cmd(4'b0001);
    other_cmd(4'b1000);
    other_cmd(4'b0100);
    other_cmd(4'b0110);
    for (int b = 0; b < DEPTH / BEATS; b++) begin
      rd_burst(AW'(b * BEATS * 8), 1'b0, "R10 memory unchanged");
    end

    // write held on the port during a read must be dropped (R8)
    rd_burst(AW'(40 * 8), 1'b1, "R8 poke read");
    rd_burst(AW'(40 * 8), 1'b0, "R8 poke had no effect");

    // open burst closed by a read, then a fresh burst (R6)
    wr_burst(AW'(8 * 8), 3, 1'b0, 1'b1, "R6 open");
    rd_burst(AW'(0), 1'b0, "R6 read closes");
    wr_burst(AW'(30 * 8), 2, 1'b1, 1'b1, "R6 fresh start");
    rd_burst(AW'(8 * 8), 1'b0, "R6 check open");
    rd_burst(AW'(28 * 8), 1'b0, "R6 check fresh");

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 3) begin
        rd_burst($urandom(), bit'($urandom_range(0, 1)), "R3 random read");
      end else if (op <= 6) begin
        wr_burst($urandom(), $urandom_range(1, BEATS), 1'b1, 1'b0, "R6 R7 random");
      end else if (op == 7) begin
        wr_burst($urandom(), $urandom_range(1, 3), 1'b0, 1'b0, "R6 random open");
      end else if (op == 8) begin
        other_cmd(pick_other());
      end else begin
        idle($urandom_range(1, 3));
      end
    end

    for (int b = 0; b < DEPTH / BEATS; b++) begin
      rd_burst(AW'(b * BEATS * 8), 1'b0, "R3 final sweep");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule